// File: doc/BRIEF.md
# Lockable Watchdog Timer with Clear Handshake

This block is a memory-mapped watchdog. It has a 32-bit down-counter, a key-protected write lock, and an interrupt-clear operation that reports through a busy bit while the clear is still settling. Software reaches it over a plain register bus made of an address, a write enable, write data and combinational read data.

To arm the watchdog, software first unlocks the registers. It then writes a preset into the load register and fires the reload strobe, which copies the preset into the counter. Finally it sets the run bit. The counter steps down once on every cycle in which the run bit and the external counting enable are both high. When the counter steps from one to zero, the interrupt is raised. If resets are enabled, a one-cycle reset request is also issued. After that the counter stays at zero until the next reload.

A periodic service sequence clears the interrupt and reloads the counter. Writing any value other than the key to the lock register closes the block again.

Top module: `wdg_timer`

## Requirements
- R1: After reset the block is locked, the interrupt and reset request are low, and the counter, preset, reset-enable and run bits all read 0.
- R2: Writing 0x378F0765 to the lock register (0x13C) unlocks the block, and writing any other value to it locks the block. Reading the lock register returns 1 in bit 0 while locked and 0 while unlocked.
- R3: While the block is locked, every write to any address other than 0x13C is ignored. Reads work whether the block is locked or not.
- R4: A write to the load register (0x108) changes the readable preset but not the counter. A write of any value to the reload register (0x114) copies the preset into the counter.
- R5: The counter reads back at 0x118. It decreases by exactly one per cycle only while bit 0 of the run register (0x110) is 1 and the counting enable input is high; otherwise it holds its value.
- R6: When the counter steps from 1 to 0, the interrupt is set and the status register (0x000) reads 1. The counter then stays at 0 until a reload.
- R7: On that expiry the reset request is high for exactly one cycle, but only if bit 0 of the control register (0x104) is 1. With that bit at 0, no reset request is issued.
- R8: A write to the clear register (0x120) with bit 0 set removes a pending interrupt. A write there with bit 0 clear has no effect.
- R9: After an accepted clear, bit 1 of the clear register reads 1 for CLR_BUSY_CYC cycles (default 4). Any clear written while that bit is 1 is ignored.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| busAddr | input | 12 | Register byte address |
| busWe | input | 1 | Write strobe, one cycle per write |
| busWdata | input | 32 | Write data |
| busRdata | output | 32 | Read data for busAddr (combinational) |
| cntEn | input | 1 | Counting clock enable |
| irqOut | output | 1 | Timeout interrupt, held until cleared |
| rstReq | output | 1 | One-cycle reset request on expiry |

## Verification
The bench builds the block with its defaults: a 32-bit counter, a 12-bit address, the listed unlock key and a four-cycle clear-busy window. Small presets such as 2, 3 and 5 make an expiry happen within a few cycles. The four-cycle busy window is short enough that a second clear can be made to land inside it, right after a fresh expiry, which shows the ignored clear at the interrupt pin. The same window then lapses early enough for a follow-up clear to be accepted.

// File: rtl/wdg_pkg.sv
`timescale 1ns/1ps
package wdg_pkg;
  // Byte offsets decoded by the register bus
  localparam int unsigned ADR_STAT   = 'h000;
  localparam int unsigned ADR_CTRL   = 'h104;
  localparam int unsigned ADR_LOAD   = 'h108;
  localparam int unsigned ADR_RUN    = 'h110;
  localparam int unsigned ADR_RELOAD = 'h114;
  localparam int unsigned ADR_VALUE  = 'h118;
  localparam int unsigned ADR_CLEAR  = 'h120;
  localparam int unsigned ADR_LOCK   = 'h13C;

  // Strobes from control to datapath
  typedef struct packed {
    logic loadWr;
    logic reloadWr;
    logic irqClr;
  } wdgStrobe_t;
endpackage

// File: rtl/wdg_ctrl.sv
`timescale 1ns/1ps
module wdg_ctrl
  import wdg_pkg::*;
#(
  parameter int unsigned ADDR_W       = 12,
  parameter int unsigned DATA_W       = 32,
  parameter int unsigned CLR_BUSY_CYC = 4,
  parameter logic [31:0] UNLOCK_KEY   = 32'h378F0765
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic              busWe,
  input  logic [DATA_W-1:0] busWdata,
  output wdgStrobe_t        strb,
  output logic              locked,
  output logic              rstEn,
  output logic              runEn,
  output logic              clrBusy
);
  localparam int unsigned BUSY_W = $clog2(CLR_BUSY_CYC + 1);

  logic              wrOk;
  logic [BUSY_W-1:0] busyCnt;

  assign wrOk    = busWe && !locked;
  assign clrBusy = (busyCnt != '0);

  always_comb begin
    strb.loadWr   = wrOk && (busAddr == ADDR_W'(ADR_LOAD));
    strb.reloadWr = wrOk && (busAddr == ADDR_W'(ADR_RELOAD));
    strb.irqClr   = wrOk && (busAddr == ADDR_W'(ADR_CLEAR)) && busWdata[0] && !clrBusy;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      locked  <= 1'b1;
      rstEn   <= 1'b0;
      runEn   <= 1'b0;
      busyCnt <= '0;
    end else begin
      if (busWe && (busAddr == ADDR_W'(ADR_LOCK)))
        locked <= (busWdata[31:0] != UNLOCK_KEY);
      if (wrOk && (busAddr == ADDR_W'(ADR_CTRL)))
        rstEn <= busWdata[0];
      if (wrOk && (busAddr == ADDR_W'(ADR_RUN)))
        runEn <= busWdata[0];
      if (strb.irqClr)
        busyCnt <= BUSY_W'(CLR_BUSY_CYC);
      else if (clrBusy)
        busyCnt <= busyCnt - 1'b1;
    end
  end
endmodule

// File: rtl/wdg_datapath.sv
`timescale 1ns/1ps
module wdg_datapath
  import wdg_pkg::*;
#(
  parameter int unsigned CNT_W = 32
) (
  input  logic             clk,
  input  logic             rstN,
  input  wdgStrobe_t       strb,
  input  logic [CNT_W-1:0] wrData,
  input  logic             runEn,
  input  logic             rstEn,
  input  logic             cntEn,
  output logic [CNT_W-1:0] loadVal,
  output logic [CNT_W-1:0] count,
  output logic             irq,
  output logic             rstReq
);
  logic tick;
  logic expire;

  assign tick   = runEn && cntEn;
  assign expire = tick && (count == CNT_W'(1)) && !strb.reloadWr;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      loadVal <= '0;
      count   <= '0;
      irq     <= 1'b0;
      rstReq  <= 1'b0;
    end else begin
      if (strb.loadWr)
        loadVal <= wrData;
      if (strb.reloadWr)
        count <= loadVal;
      else if (tick && (count != '0))
        count <= count - 1'b1;
      if (expire)
        irq <= 1'b1;
      else if (strb.irqClr)
        irq <= 1'b0;
      rstReq <= expire && rstEn;
    end
  end
endmodule

// File: rtl/wdg_timer.sv
`timescale 1ns/1ps
module wdg_timer
  import wdg_pkg::*;
#(
  parameter int unsigned ADDR_W       = 12,
  parameter int unsigned CNT_W        = 32,
  parameter int unsigned CLR_BUSY_CYC = 4,
  parameter logic [31:0] UNLOCK_KEY   = 32'h378F0765
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic              busWe,
  input  logic [31:0]       busWdata,
  output logic [31:0]       busRdata,
  input  logic              cntEn,
  output logic              irqOut,
  output logic              rstReq
);
  localparam int unsigned DATA_W = 32;

  wdgStrobe_t       strb;
  logic             locked;
  logic             rstEn;
  logic             runEn;
  logic             clrBusy;
  logic [CNT_W-1:0] loadVal;
  logic [CNT_W-1:0] count;

  wdg_ctrl #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W),
    .CLR_BUSY_CYC(CLR_BUSY_CYC), .UNLOCK_KEY(UNLOCK_KEY)
  ) ctrl_i (
    .clk(clk), .rstN(rstN), .busAddr(busAddr), .busWe(busWe),
    .busWdata(busWdata), .strb(strb), .locked(locked),
    .rstEn(rstEn), .runEn(runEn), .clrBusy(clrBusy)
  );

  wdg_datapath #(.CNT_W(CNT_W)) dp_i (
    .clk(clk), .rstN(rstN), .strb(strb), .wrData(busWdata[CNT_W-1:0]),
    .runEn(runEn), .rstEn(rstEn), .cntEn(cntEn),
    .loadVal(loadVal), .count(count), .irq(irqOut), .rstReq(rstReq)
  );

  always_comb begin
    busRdata = '0;
    case (busAddr)
      ADDR_W'(ADR_STAT):   busRdata = {31'b0, irqOut};
      ADDR_W'(ADR_CTRL):   busRdata = {31'b0, rstEn};
      ADDR_W'(ADR_LOAD):   busRdata = DATA_W'(loadVal);
      ADDR_W'(ADR_RUN):    busRdata = {31'b0, runEn};
      ADDR_W'(ADR_VALUE):  busRdata = DATA_W'(count);
      ADDR_W'(ADR_CLEAR):  busRdata = {30'b0, clrBusy, 1'b0};
      ADDR_W'(ADR_LOCK):   busRdata = {31'b0, locked};
      default:             busRdata = '0;
    endcase
  end
endmodule

// File: rtl/wdg_timer_chk.sv
`timescale 1ns/1ps
module wdg_timer_chk
  import wdg_pkg::*;
#(
  parameter int unsigned ADDR_W = 12,
  parameter int unsigned CNT_W  = 32
) (
  input logic              clk,
  input logic              rstN,
  input logic [ADDR_W-1:0] busAddr,
  input logic              busWe,
  input logic              locked,
  input logic [CNT_W-1:0]  loadVal,
  input logic [CNT_W-1:0]  count,
  input logic              irqOut,
  input logic              rstReq,
  input logic              clrBusy
);
  logic reloadHit;
  assign reloadHit = busWe && !locked && (busAddr == ADDR_W'(ADR_RELOAD));

  AST_LOCKED_LOAD_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    (locked && busWe && busAddr == ADDR_W'(ADR_LOAD)) |=> $stable(loadVal)); // R3
  AST_COUNT_STEP: assert property (@(posedge clk) disable iff (!rstN)
    !reloadHit |=> (count == $past(count) || count == $past(count) - 1'b1)); // R5
  AST_ZERO_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    (count == '0 && !reloadHit) |=> (count == '0)); // R6
  AST_RST_SINGLE: assert property (@(posedge clk) disable iff (!rstN)
    rstReq |=> !rstReq); // R7
  AST_RST_WITH_IRQ: assert property (@(posedge clk) disable iff (!rstN)
    rstReq |-> irqOut); // R7
  AST_BUSY_KEEPS_IRQ: assert property (@(posedge clk) disable iff (!rstN)
    (clrBusy && irqOut) |=> irqOut); // R9
endmodule

bind wdg_timer wdg_timer_chk #(.ADDR_W(ADDR_W), .CNT_W(CNT_W)) chk_i (
  .clk(clk), .rstN(rstN), .busAddr(busAddr), .busWe(busWe),
  .locked(locked), .loadVal(loadVal), .count(count),
  .irqOut(irqOut), .rstReq(rstReq), .clrBusy(clrBusy)
);

// File: tb/wdg_timer_tb_top.sv
`timescale 1ns/1ps
module wdg_timer_tb_top;
  localparam logic [31:0] KEY = 32'h378F0765;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [11:0] busAddr = '0;
  logic        busWe = 1'b0;
  logic [31:0] busWdata = '0;
  logic [31:0] busRdata;
  logic        cntEn = 1'b1;
  logic        irqOut;
  logic        rstReq;

  int checks = 0;
  int fails = 0;
  int rstSeen = 0;
  bit finished = 1'b0;

  always #5 clk = ~clk;

  wdg_timer #(.ADDR_W(12), .CNT_W(32), .CLR_BUSY_CYC(4), .UNLOCK_KEY(KEY)) dut_i (
    .clk(clk), .rstN(rstN), .busAddr(busAddr), .busWe(busWe),
    .busWdata(busWdata), .busRdata(busRdata), .cntEn(cntEn),
    .irqOut(irqOut), .rstReq(rstReq)
  );

  always @(negedge clk) if (rstN && rstReq) rstSeen++;

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [11:0] a, input logic [31:0] d);
    busAddr = a; busWdata = d; busWe = 1'b1;
    @(posedge clk); @(negedge clk);
    busWe = 1'b0;
  endtask

  task automatic rd(input logic [11:0] a, output logic [31:0] d);
    busAddr = a; #1; d = busRdata;
  endtask

  task automatic cycles(input int n);
    repeat (n) @(posedge clk);
    @(negedge clk);
  endtask

  task automatic t_reset();
    logic [31:0] v;
    rd(12'h13C, v); chk("R1 lock bit", v, 1);
    rd(12'h118, v); chk("R1 counter", v, 0);
    rd(12'h104, v); chk("R1 control", v, 0);
    chk("R1 irq", {31'b0, irqOut}, 0);
    chk("R1 rstReq", {31'b0, rstReq}, 0);
  endtask

  task automatic t_lock();
    logic [31:0] v;
    wr(12'h108, 32'h55);
    rd(12'h108, v); chk("R3 locked load write ignored", v, 0);
    wr(12'h13C, KEY);
    rd(12'h13C, v); chk("R2 unlocked by key", v, 0);
    wr(12'h108, 32'h55);
    rd(12'h108, v); chk("R3 load write when unlocked", v, 32'h55);
    wr(12'h13C, 32'h12345678);
    rd(12'h13C, v); chk("R2 relocked by other value", v, 1);
    wr(12'h108, 32'h99);
    rd(12'h108, v); chk("R3 relocked write ignored", v, 32'h55);
    wr(12'h13C, KEY);
  endtask

  task automatic t_count();
    logic [31:0] v;
    wr(12'h108, 32'd5);
    rd(12'h118, v); chk("R4 load alone leaves counter", v, 0);
    wr(12'h114, 32'hABCD);
    rd(12'h118, v); chk("R4 reload copies preset", v, 5);
    cycles(3);
    rd(12'h118, v); chk("R5 hold while run bit 0", v, 5);
    wr(12'h110, 32'h1);
    cycles(2);
    rd(12'h118, v); chk("R5 decrement two cycles", v, 3);
    cntEn = 1'b0;
    cycles(3);
    rd(12'h118, v); chk("R5 hold while cntEn low", v, 3);
    cntEn = 1'b1;
    cycles(2);
    rd(12'h118, v); chk("R5 value before expiry", v, 1);
    chk("R6 irq low before expiry", {31'b0, irqOut}, 0);
    cycles(1);
    chk("R6 irq on expiry", {31'b0, irqOut}, 1);
    rd(12'h000, v); chk("R6 status pending", v, 1);
    cycles(3);
    rd(12'h118, v); chk("R6 counter held at zero", v, 0);
    chk("R7 no reset request when disabled", rstSeen, 0);
  endtask

  task automatic t_clear();
    logic [31:0] v;
    wr(12'h108, 32'd2);
    wr(12'h120, 32'h2);
    chk("R8 clear with bit0 low ignored", {31'b0, irqOut}, 1);
    rd(12'h120, v); chk("R9 not busy after ignored clear", v, 0);
    wr(12'h120, 32'h1);
    chk("R8 clear removes irq", {31'b0, irqOut}, 0);
    rd(12'h120, v); chk("R9 busy bit after clear", v, 2);
    rd(12'h000, v); chk("R8 status idle", v, 0);
    wr(12'h114, 32'h0);
    cycles(2);
    chk("R6 second expiry", {31'b0, irqOut}, 1);
    wr(12'h120, 32'h1);
    chk("R9 clear while busy ignored", {31'b0, irqOut}, 1);
    rd(12'h120, v); chk("R9 busy window over", v, 0);
    wr(12'h120, 32'h1);
    chk("R8 clear after busy accepted", {31'b0, irqOut}, 0);
  endtask

  task automatic t_reset_req();
    logic [31:0] v;
    wr(12'h110, 32'h0);
    wr(12'h108, 32'd3);
    wr(12'h114, 32'h1);
    wr(12'h104, 32'h1);
    wr(12'h110, 32'h1);
    cycles(2);
    rd(12'h118, v); chk("R5 preset 3 after two ticks", v, 1);
    chk("R7 no pulse before expiry", {31'b0, rstReq}, 0);
    cycles(1);
    chk("R7 pulse on expiry", {31'b0, rstReq}, 1);
    chk("R6 irq with pulse", {31'b0, irqOut}, 1);
    cycles(1);
    chk("R7 pulse lasts one cycle", {31'b0, rstReq}, 0);
    cycles(3);
    chk("R7 exactly one pulse", rstSeen, 1);
    wr(12'h13C, 32'h0);
    wr(12'h104, 32'h0);
    rd(12'h104, v); chk("R3 locked control write ignored", v, 1);
  endtask

  task automatic summary();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  endtask

  initial begin
    #1_000_000;
    if (!finished) begin
      checks++; fails++;
      $display("FAIL watchdog expired actual=hung expected=done");
      summary();
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    rstN = 1'b1;
    t_reset();
    t_lock();
    t_count();
    t_clear();
    t_reset_req();
    finished = 1'b1;
    summary();
  end
endmodule